// File: doc/BRIEF.md
# Input Change Latch with Interrupt

This block watches sixteen port pins and records every change of logic level on the pins that are set as inputs. Each pin passes through a synchroniser. The synchronised value is then compared with the value taken one cycle earlier. A difference in either direction sets that port's bit in a sixteen-bit change register. The bit stays set until software reads the register. An active-low interrupt line is asserted while at least one bit is set.

A read strobe does two things at once. It copies the register into the read-data output and it clears the register. A change that is captured in the same cycle as the read is kept for the next read. It is never lost. Ports set as outputs can never set a bit. The block needs no enable, so detection goes on in every power state of the surrounding chip.

A two-state controller guards the start-up phase. In `ST_PRIME`, entered on reset, the synchroniser fills and the reference value loads from the pins, and no change can be recorded. After `SYNC_STAGES + 1` clock edges the controller takes the transition `PRIME_DONE` into `ST_WATCH`. It stays there until the next reset. A change of a pin's direction masks that pin for one cycle. This keeps the switch itself from being counted as a change.

Top module: `edge_latch_irq`

## Requirements
- R1: While reset is asserted and after it is released, `irq_n_o` is 1 and `rd_data_o` is 0 until a change is latched and read.
- R2: A 0-to-1 change on a pin whose `dir_in_i` bit is 1 (1 = input) sets that bit of the change register. `irq_n_o` reads 0 after the third rising clock edge that follows the change.
- R3: A 1-to-0 change on an input pin sets its bit in the same way as R2.
- R4: A pin whose `dir_in_i` bit is 0 (output) never sets its bit, however its level moves.
- R5: `irq_n_o` is 0 exactly while at least one bit of the change register is set. With no read it stays 0.
- R6: When `rd_stb_i` is high at a clock edge, that edge loads `rd_data_o` with the register value from just before the edge and clears the register. `irq_n_o` returns to 1 if nothing new was captured.
- R7: A change captured at the same edge as a clearing read stays set in the register and shows up on the following read.
- R8: Pins that are already high when reset is released raise no bit.
- R9: Switching a pin from output to input while its level differs from the level at its last input sample raises no bit. Later changes on that pin are detected.
- R10: `rd_data_o` holds its value between read strobes.
- R11: Changes on several pins at different times add up in the register, and one read returns them all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Raw port pin levels, asynchronous to `clk` |
| dir_in_i | input | 16 | Per-port direction, 1 = input, 0 = output |
| rd_stb_i | input | 1 | One-cycle strobe that reads and clears the change register |
| rd_data_o | output | 16 | Change register value captured by the last strobe |
| irq_n_o | output | 1 | Active-low interrupt, 0 while any change bit is set |

## Verification
A stale reference value would show up as a spurious interrupt three edges after reset or after a direction switch, with the stray bit returned on the next read. A clear that runs ahead of the capture would show up at once, in the cycle after the strobe, as a read value missing a bit that was set. A dropped coincident change would show up as an interrupt that rises too early and a second read that returns zero. A mask that leaks output pins through would show up as a low interrupt three edges after the output level moves.

// File: rtl/eli_pkg.sv
package eli_pkg;
    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_WATCH = 1'b1
    } eli_state_e;

    localparam int unsigned ELI_PORTS     = 16;
    localparam int unsigned ELI_SYNC_STGS = 2;
endpackage

// File: rtl/eli_sync.sv
module eli_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= '0;
                end else if (g == 0) begin
                    stg_q[g] <= raw_i;
                end else begin
                    stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/eli_ctl.sv
module eli_ctl
    import eli_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic watch_o
);
    localparam int unsigned CW = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [CW-1:0] PRIME_LAST = CW'(SYNC_STAGES);

    eli_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        watch_o = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                if (cnt_q == PRIME_LAST) begin
                    state_d = ST_WATCH;   // PRIME_DONE
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WATCH: begin
                watch_o = 1'b1;
            end
            default: begin
                state_d = ST_PRIME;
                cnt_d   = '0;
            end
        endcase
    end
endmodule

// File: rtl/eli_latch.sv
module eli_latch #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] smp_i,
    input  logic [WIDTH-1:0] dir_in_i,
    input  logic             watch_i,
    input  logic             rd_stb_i,
    output logic [WIDTH-1:0] flags_o,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] ref_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] flags_q;
    logic [WIDTH-1:0] rd_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] kept;

    always_comb begin
        hit  = (smp_i ^ ref_q) & dir_in_i & dir_q & {WIDTH{watch_i}};
        kept = rd_stb_i ? '0 : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q   <= '0;
            dir_q   <= '0;
            flags_q <= '0;
            rd_q    <= '0;
        end else begin
            ref_q   <= smp_i;
            dir_q   <= dir_in_i;
            flags_q <= kept | hit;
            if (rd_stb_i) begin
                rd_q <= flags_q;
            end
        end
    end

    assign flags_o   = flags_q;
    assign rd_data_o = rd_q;
endmodule

// File: rtl/edge_latch_irq.sv
module edge_latch_irq
    import eli_pkg::*;
#(
    parameter int unsigned PORTS       = ELI_PORTS,
    parameter int unsigned SYNC_STAGES = ELI_SYNC_STGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] pin_i,
    input  logic [PORTS-1:0] dir_in_i,
    input  logic             rd_stb_i,
    output logic [PORTS-1:0] rd_data_o,
    output logic             irq_n_o
);
    logic [PORTS-1:0] smp;
    logic [PORTS-1:0] flags_q;
    logic             watch_en;

    eli_sync #(.WIDTH(PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .sync_o (smp)
    );

    eli_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .watch_o (watch_en)
    );

    eli_latch #(.WIDTH(PORTS)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (smp),
        .dir_in_i  (dir_in_i),
        .watch_i   (watch_en),
        .rd_stb_i  (rd_stb_i),
        .flags_o   (flags_q),
        .rd_data_o (rd_data_o)
    );

    assign irq_n_o = ~|flags_q;
endmodule

// File: rtl/edge_latch_irq_chk.sv
module edge_latch_irq_chk #(
    parameter int unsigned PORTS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PORTS-1:0] dir_in_i,
    input logic             rd_stb_i,
    input logic [PORTS-1:0] rd_data_o,
    input logic             irq_n_o,
    input logic [PORTS-1:0] flags,
    input logic             in_watch
);
    // R4
    out_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(dir_in_i)) == '0);

    // R5
    irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_i && !irq_n_o) |=> !irq_n_o);

    // R6
    read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> (rd_data_o == $past(flags)));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(rd_data_o));

    // R8
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_watch |-> (flags == '0));
endmodule

bind edge_latch_irq edge_latch_irq_chk #(.PORTS(PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_in_i  (dir_in_i),
    .rd_stb_i  (rd_stb_i),
    .rd_data_o (rd_data_o),
    .irq_n_o   (irq_n_o),
    .flags     (flags_q),
    .in_watch  (watch_en)
);

// File: tb/test_edge_latch_irq.sv
module test_edge_latch_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin = 16'hA5F0;
    logic [15:0] dir = 16'hFFFF;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    edge_latch_irq i_edge_latch_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .dir_in_i  (dir),
        .rd_stb_i  (rd_stb),
        .rd_data_o (rd_data),
        .irq_n_o   (irq_n)
    );

    task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(output logic [15:0] val);
        rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        val = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk(irq_n === 1'b1, "R1 irq in reset", {15'd0, irq_n}, 16'h1);
        chk(rd_data === 16'h0, "R1 rd_data in reset", rd_data, 16'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(irq_n === 1'b1, "R8 no flag after reset", {15'd0, irq_n}, 16'h1);
        do_read(v);
        chk(v === 16'h0, "R8 read after reset", v, 16'h0);
    endtask

    task automatic t_rise();
        logic [15:0] v;
        pin[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(irq_n === 1'b1, "R2 not before third edge", {15'd0, irq_n}, 16'h1);
        @(posedge clk);
        @(negedge clk);
        chk(irq_n === 1'b0, "R2 irq on rise", {15'd0, irq_n}, 16'h0);
        repeat (3) @(negedge clk);
        chk(irq_n === 1'b0, "R5 irq holds", {15'd0, irq_n}, 16'h0);
        do_read(v);
        chk(v === 16'h0001, "R6 read value", v, 16'h0001);
        chk(irq_n === 1'b1, "R6 irq released", {15'd0, irq_n}, 16'h1);
    endtask

    task automatic t_fall();
        logic [15:0] v;
        pin[4] = 1'b0;
        settle();
        chk(irq_n === 1'b0, "R3 irq on fall", {15'd0, irq_n}, 16'h0);
        do_read(v);
        chk(v === 16'h0010, "R3 read value", v, 16'h0010);
    endtask

    task automatic t_output_masked();
        logic [15:0] v;
        dir = 16'h00FF;
        repeat (2) @(negedge clk);
        pin[15:8] = ~pin[15:8];
        settle();
        chk(irq_n === 1'b1, "R4 output pins quiet", {15'd0, irq_n}, 16'h1);
        pin[9] = ~pin[9];
        settle();
        chk(irq_n === 1'b1, "R4 output pins quiet again", {15'd0, irq_n}, 16'h1);
        do_read(v);
        chk(v === 16'h0, "R4 read value", v, 16'h0);
    endtask

    task automatic t_dir_change();
        logic [15:0] v;
        dir = 16'hFFFF;
        settle();
        repeat (2) @(negedge clk);
        chk(irq_n === 1'b1, "R9 no flag on switch", {15'd0, irq_n}, 16'h1);
        pin[8] = ~pin[8];
        settle();
        chk(irq_n === 1'b0, "R9 detect after switch", {15'd0, irq_n}, 16'h0);
        do_read(v);
        chk(v === 16'h0100, "R9 read value", v, 16'h0100);
    endtask

    task automatic t_coincide();
        logic [15:0] v;
        pin[2] = ~pin[2];
        settle();
        pin[3] = ~pin[3];
        repeat (2) @(posedge clk);
        @(negedge clk);
        do_read(v);
        chk(v === 16'h0004, "R7 first read", v, 16'h0004);
        chk(irq_n === 1'b0, "R7 irq kept", {15'd0, irq_n}, 16'h0);
        do_read(v);
        chk(v === 16'h0008, "R7 second read", v, 16'h0008);
        chk(irq_n === 1'b1, "R7 irq released", {15'd0, irq_n}, 16'h1);
    endtask

    task automatic t_multi();
        logic [15:0] v;
        pin[1] = ~pin[1];
        settle();
        pin[12] = ~pin[12];
        repeat (2) @(negedge clk);
        pin[15] = ~pin[15];
        settle();
        do_read(v);
        chk(v === 16'h9002, "R11 accumulated", v, 16'h9002);
        pin[6] = ~pin[6];
        settle();
        repeat (4) @(negedge clk);
        chk(rd_data === 16'h9002, "R10 rd_data held", rd_data, 16'h9002);
        do_read(v);
        chk(v === 16'h0040, "R11 next read", v, 16'h0040);
    endtask

    initial begin
        #1;
        t_reset();
        t_rise();
        t_fall();
        t_output_masked();
        t_dir_change();
        t_coincide();
        t_multi();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule